// File: doc/BRIEF.md
# Sixteen-Channel Charge Sum and Peak Finder

This block is the first processing step for a group of sixteen photomultiplier channels. In every clock cycle it takes one 10-bit sample per channel and rescales each sample by that channel's own gain factor. It then removes the channel's pedestal, so that every channel reports charge on a common scale.

From the corrected charges it forms four results: the total charge, the channel holding the largest charge together with that charge, and the earliest arrival time among the channels whose time tag is flagged valid. These results are packed into one 48-bit word for the link to the next processing layer. A new sample set can enter on every cycle, and each result word appears a fixed number of cycles after its inputs.

Gain and pedestal values sit in small per-channel tables. They are written through a single-cycle write port and keep their values until they are written again.

Top module: `qsum_peak`

## Requirements
- R1: The corrected charge of a channel is floor(sample * gain / 64) - pedestal, saturated at 1023. The gain is an unsigned 8-bit value with 6 fractional bits.
- R2: When the rescaled sample is less than or equal to the pedestal, the corrected charge is 0.
- R3: With `cfg_we` high, `cfg_addr[4]` = 0 writes `cfg_wdata[7:0]` to the gain of channel `cfg_addr[3:0]`, and `cfg_addr[4]` = 1 writes `cfg_wdata[9:0]` to that channel's pedestal. After reset every gain is 64 (unity) and every pedestal is 0. A write applies to sample sets captured two or more edges after the write edge. With `cfg_we` low, the tables do not change.
- R4: `link_word[17:0]` holds the sum of the sixteen corrected charges.
- R5: `link_word[21:18]` holds the index of the channel with the largest corrected charge and `link_word[31:22]` holds that charge. On a tie, the lower index wins.
- R6: `link_word[39:32]` holds the smallest `in_times` entry among channels whose `in_time_ok` bit is 1. If no bit is set, it holds 0xFF.
- R7: A sample set captured on a rising edge with `in_valid` high appears on the outputs right after the sixth following rising edge, with `link_valid` = 1 and `link_word[40]` = 1. Sets on consecutive cycles give words on consecutive cycles.
- R8: When no result is due, `link_valid` is 0 and `link_word` is all zero. Bits [47:41] are always 0, and inputs offered with `in_valid` low produce no word.
- R9: While reset is asserted, and for the synchronous release that follows it, the outputs are zero and any stimulus is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample set present this cycle |
| in_samples | input | 160 | Channel c sample at bits [10c+9:10c] |
| in_times | input | 128 | Channel c arrival time at bits [8c+7:8c] |
| in_time_ok | input | 16 | Bit c marks channel c's time as valid |
| cfg_we | input | 1 | Table write strobe |
| cfg_addr | input | 5 | Bit 4 selects pedestal (1) or gain (0); bits 3:0 select the channel |
| cfg_wdata | input | 10 | Write data |
| link_word | output | 48 | Packed result word |
| link_valid | output | 1 | Result word present |

## Verification
On every cycle, the assertions check four things:
- the six-edge latency of the valid marker against `in_valid`;
- that idle words are all zero;
- that the sum is never smaller than the reported maximum and never exceeds sixteen full-scale charges;
- that the gain and pedestal tables change only on a write and take the written value.

The arithmetic itself can only be shown by the bench's scenarios, which compare whole words against an independent model. These scenarios cover saturation and clamping of single channels, tie resolution in the peak search, the all-invalid time case, back-to-back sets, and the rule that stimulus during reset or with `in_valid` low is dropped.

// File: rtl/qsum_peak_pkg.sv
package qsum_peak_pkg;
  parameter int unsigned NCH       = 16;
  parameter int unsigned SMP_W     = 10;
  parameter int unsigned GAIN_W    = 8;
  parameter int unsigned GAIN_FRAC = 6;
  parameter int unsigned TIME_W    = 8;
  parameter int unsigned SUM_W     = 18;
  parameter int unsigned LINK_W    = 48;

  localparam int unsigned IDX_W      = $clog2(NCH);
  localparam int unsigned LVLS       = $clog2(NCH);
  localparam int unsigned PROD_W     = SMP_W + GAIN_W;
  localparam int unsigned LAT        = 2 + LVLS;
  localparam int unsigned CFG_ADDR_W = IDX_W + 1;
  localparam int unsigned CFG_DATA_W = SMP_W;

  localparam int unsigned IDX_LSB  = SUM_W;
  localparam int unsigned MAXV_LSB = IDX_LSB + IDX_W;
  localparam int unsigned TIME_LSB = MAXV_LSB + SMP_W;
  localparam int unsigned VLD_BIT  = TIME_LSB + TIME_W;
  localparam int unsigned RSV_W    = LINK_W - VLD_BIT - 1;

  typedef struct packed {
    logic [SUM_W-1:0]  sum;
    logic [SMP_W-1:0]  maxv;
    logic [IDX_W-1:0]  maxi;
    logic [TIME_W-1:0] tmin;
    logic              thit;
  } node_t;

  // Combine two partial results; "a" always covers the lower channel indices.
  function automatic node_t merge(input node_t a, input node_t b);
    node_t r;
    r.sum = a.sum + b.sum;
    if (b.maxv > a.maxv) begin
      r.maxv = b.maxv;
      r.maxi = b.maxi;
    end else begin
      r.maxv = a.maxv;
      r.maxi = a.maxi;
    end
    if (a.thit && b.thit) begin
      r.tmin = (b.tmin < a.tmin) ? b.tmin : a.tmin;
      r.thit = 1'b1;
    end else if (b.thit) begin
      r.tmin = b.tmin;
      r.thit = 1'b1;
    end else begin
      r.tmin = a.tmin;
      r.thit = a.thit;
    end
    return r;
  endfunction
endpackage

// File: rtl/qsum_peak_rst_sync.sv
module qsum_peak_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/qsum_peak_cfg.sv
module qsum_peak_cfg
  import qsum_peak_pkg::*;
(
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               cfg_we,
  input  logic [CFG_ADDR_W-1:0]              cfg_addr,
  input  logic [CFG_DATA_W-1:0]              cfg_wdata,
  output logic [NCH-1:0][GAIN_W-1:0]         gain_tab,
  output logic [NCH-1:0][SMP_W-1:0]          ped_tab
);
  localparam logic [GAIN_W-1:0] GAIN_UNITY = GAIN_W'(1 << GAIN_FRAC);

  logic [NCH-1:0][GAIN_W-1:0] gain_d;
  logic [NCH-1:0][SMP_W-1:0]  ped_d;
  logic [IDX_W-1:0]           sel;

  assign sel = cfg_addr[IDX_W-1:0];

  always_comb begin
    gain_d = gain_tab;
    ped_d  = ped_tab;
    if (cfg_we) begin
      if (cfg_addr[IDX_W]) begin
        ped_d[sel] = cfg_wdata[SMP_W-1:0];
      end else begin
        gain_d[sel] = cfg_wdata[GAIN_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain_tab <= {NCH{GAIN_UNITY}};
      ped_tab  <= '0;
    end else if (cfg_we) begin
      gain_tab <= gain_d;
      ped_tab  <= ped_d;
    end
  end
endmodule

// File: rtl/qsum_peak_chan.sv
module qsum_peak_chan
  import qsum_peak_pkg::*;
#(
  parameter int unsigned CH = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_mul,
  input  logic              en_sub,
  input  logic [SMP_W-1:0]  sample,
  input  logic [GAIN_W-1:0] gain,
  input  logic [SMP_W-1:0]  pedestal,
  input  logic [TIME_W-1:0] t_in,
  input  logic              t_ok,
  output node_t             leaf
);
  localparam int unsigned      SCL_W   = PROD_W - GAIN_FRAC;
  localparam logic [SMP_W-1:0] CHG_MAX = '1;

  logic [PROD_W-1:0] prod_d, prod_q;
  logic [SCL_W-1:0]  scaled, ped_ext, diff;
  logic [SMP_W-1:0]  chg_d, chg_q;
  logic [TIME_W-1:0] t1_q, t2_q;
  logic              ok1_q, ok2_q;

  assign prod_d  = PROD_W'(sample) * PROD_W'(gain);
  assign scaled  = prod_q[PROD_W-1:GAIN_FRAC];
  assign ped_ext = SCL_W'(pedestal);
  assign diff    = scaled - ped_ext;

  // clamp below at zero, saturate above at full scale
  always_comb begin
    if (scaled <= ped_ext) begin
      chg_d = '0;
    end else if (diff > SCL_W'(CHG_MAX)) begin
      chg_d = CHG_MAX;
    end else begin
      chg_d = diff[SMP_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_q <= '0;
      t1_q   <= '0;
      ok1_q  <= 1'b0;
    end else if (en_mul) begin
      prod_q <= prod_d;
      t1_q   <= t_in;
      ok1_q  <= t_ok;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chg_q <= '0;
      t2_q  <= '0;
      ok2_q <= 1'b0;
    end else if (en_sub) begin
      chg_q <= chg_d;
      t2_q  <= t1_q;
      ok2_q <= ok1_q;
    end
  end

  always_comb begin
    leaf.sum  = SUM_W'(chg_q);
    leaf.maxv = chg_q;
    leaf.maxi = IDX_W'(CH);
    leaf.tmin = ok2_q ? t2_q : '1;
    leaf.thit = ok2_q;
  end
endmodule

// File: rtl/qsum_peak_level.sv
module qsum_peak_level
  import qsum_peak_pkg::*;
#(
  parameter int unsigned NIN = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  node_t [NIN-1:0]       nodes_in,
  output node_t [NIN/2-1:0]     nodes_out
);
  localparam int unsigned NOUT = NIN / 2;

  node_t [NOUT-1:0] nxt;

  always_comb begin
    for (int i = 0; i < NOUT; i++) begin
      nxt[i] = merge(nodes_in[2*i], nodes_in[2*i+1]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nodes_out <= '0;
    end else if (en) begin
      nodes_out <= nxt;
    end
  end
endmodule

// File: rtl/qsum_peak.sv
module qsum_peak
  import qsum_peak_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [NCH*SMP_W-1:0]     in_samples,
  input  logic [NCH*TIME_W-1:0]    in_times,
  input  logic [NCH-1:0]           in_time_ok,
  input  logic                     cfg_we,
  input  logic [CFG_ADDR_W-1:0]    cfg_addr,
  input  logic [CFG_DATA_W-1:0]    cfg_wdata,
  output logic [LINK_W-1:0]        link_word,
  output logic                     link_valid
);
  logic rst_sync_n;

  qsum_peak_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  logic [NCH-1:0][GAIN_W-1:0] gain_tab;
  logic [NCH-1:0][SMP_W-1:0]  ped_tab;

  qsum_peak_cfg u_cfg (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .cfg_we   (cfg_we),
    .cfg_addr (cfg_addr),
    .cfg_wdata(cfg_wdata),
    .gain_tab (gain_tab),
    .ped_tab  (ped_tab)
  );

  // stage valid chain: bit 0 is the capture stage, bit LAT the result
  logic [LAT:0] vpipe_d, vpipe_q;

  always_comb begin
    vpipe_d = {vpipe_q[LAT-1:0], in_valid};
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vpipe_q <= '0;
    end else begin
      vpipe_q <= vpipe_d;
    end
  end

  // input capture
  logic [NCH*SMP_W-1:0]  samp_q;
  logic [NCH*TIME_W-1:0] time_q;
  logic [NCH-1:0]        tok_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      samp_q <= '0;
      time_q <= '0;
      tok_q  <= '0;
    end else if (in_valid) begin
      samp_q <= in_samples;
      time_q <= in_times;
      tok_q  <= in_time_ok;
    end
  end

  // per-channel calibration
  node_t [NCH-1:0] leaves;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    qsum_peak_chan #(.CH(c)) u_ch (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .en_mul  (vpipe_q[0]),
      .en_sub  (vpipe_q[1]),
      .sample  (samp_q[c*SMP_W +: SMP_W]),
      .gain    (gain_tab[c]),
      .pedestal(ped_tab[c]),
      .t_in    (time_q[c*TIME_W +: TIME_W]),
      .t_ok    (tok_q[c]),
      .leaf    (leaves[c])
    );
  end

  // pairwise reduction, one registered level per stage
  for (genvar l = 0; l < LVLS; l++) begin : g_lvl
    localparam int unsigned NIN = NCH >> l;
    node_t [NIN-1:0]   d;
    node_t [NIN/2-1:0] q;
    if (l == 0) begin : g_src
      assign d = leaves;
    end else begin : g_src
      assign d = g_lvl[l-1].q;
    end
    qsum_peak_level #(.NIN(NIN)) u_lvl (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .en       (vpipe_q[2+l]),
      .nodes_in (d),
      .nodes_out(q)
    );
  end

  node_t root;
  assign root = g_lvl[LVLS-1].q[0];

  assign link_valid = vpipe_q[LAT];

  always_comb begin
    if (vpipe_q[LAT]) begin
      link_word = {{RSV_W{1'b0}}, 1'b1, root.tmin, root.maxv, root.maxi, root.sum};
    end else begin
      link_word = '0;
    end
  end
endmodule

// File: rtl/qsum_peak_chk.sv
module qsum_peak_chk
  import qsum_peak_pkg::*;
(
  input logic                        clk,
  input logic                        rst_sync_n,
  input logic                        in_valid,
  input logic                        cfg_we,
  input logic [CFG_ADDR_W-1:0]       cfg_addr,
  input logic [CFG_DATA_W-1:0]       cfg_wdata,
  input logic [NCH-1:0][GAIN_W-1:0]  gain_tab,
  input logic [NCH-1:0][SMP_W-1:0]   ped_tab,
  input logic [LINK_W-1:0]           link_word,
  input logic                        link_valid
);
  localparam int unsigned SUM_MAX = NCH * ((1 << SMP_W) - 1);

  int unsigned age_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      age_q <= 0;
    end else if (age_q < LAT + 1) begin
      age_q <= age_q + 1;
    end
  end

  // R7: marker follows in_valid by the fixed pipeline depth
  assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (age_q >= LAT + 1) |-> (link_valid == $past(in_valid, LAT + 1)));

  // R8: idle words carry nothing
  assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !link_valid |-> (link_word == '0));

  // R4: sum bounded below by the peak and above by full scale
  assert_sum_ge_max_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    link_valid |-> (link_word[SUM_W-1:0] >= SUM_W'(link_word[MAXV_LSB +: SMP_W])));

  assert_sum_bound_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    link_valid |-> (int'(link_word[SUM_W-1:0]) <= int'(SUM_MAX)));

  // R3: tables hold without a write, and a gain write lands
  assert_cfg_hold_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cfg_we |=> ($stable(gain_tab) && $stable(ped_tab)));

  assert_cfg_write_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cfg_we && !cfg_addr[IDX_W]) |=>
      (gain_tab[$past(cfg_addr[IDX_W-1:0])] == $past(cfg_wdata[GAIN_W-1:0])));
endmodule

bind qsum_peak qsum_peak_chk u_chk (
  .clk       (clk),
  .rst_sync_n(rst_sync_n),
  .in_valid  (in_valid),
  .cfg_we    (cfg_we),
  .cfg_addr  (cfg_addr),
  .cfg_wdata (cfg_wdata),
  .gain_tab  (gain_tab),
  .ped_tab   (ped_tab),
  .link_word (link_word),
  .link_valid(link_valid)
);

// File: tb/qsum_peak_tb.sv
module qsum_peak_tb;
  import qsum_peak_pkg::*;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic                  rst_n;
  logic                  in_valid;
  logic [NCH*SMP_W-1:0]  in_samples;
  logic [NCH*TIME_W-1:0] in_times;
  logic [NCH-1:0]        in_time_ok;
  logic                  cfg_we;
  logic [CFG_ADDR_W-1:0] cfg_addr;
  logic [CFG_DATA_W-1:0] cfg_wdata;
  logic [LINK_W-1:0]     link_word;
  logic                  link_valid;

  qsum_peak u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_samples(in_samples),
    .in_times(in_times), .in_time_ok(in_time_ok), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .link_word(link_word),
    .link_valid(link_valid)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  int gain_m [NCH];
  int ped_m  [NCH];
  int cur_s  [NCH];
  int cur_t  [NCH];
  int cur_m  [NCH];

  typedef struct packed {
    int base;
    int step;
    int tmask;
    int tbase;
    int tstep;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{100,   10, 'hFFFF, 200,  -5},
    '{500,    0, 'h0000,  40,   1},
    '{1023,   0, 'h8001,   7,   3},
    '{0,      0, 'h0010,  90,   2},
    '{900,  -60, 'h0F00, 250,  -1},
    '{3,     64, 'hFFFF,   0,  16}
  };

  task automatic check(input string req, input logic [LINK_W-1:0] act,
                       input logic [LINK_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [LINK_W-1:0] model();
    int sum = 0;
    int mx  = -1;
    int mi  = 0;
    int tm  = 255;
    for (int c = 0; c < NCH; c++) begin
      int q = (cur_s[c] * gain_m[c]) / 64 - ped_m[c];
      if (q < 0) q = 0;
      if (q > 1023) q = 1023;
      sum += q;
      if (q > mx) begin
        mx = q;
        mi = c;
      end
      if (cur_m[c] != 0 && cur_t[c] < tm) tm = cur_t[c];
    end
    return {7'b0, 1'b1, tm[7:0], mx[9:0], mi[3:0], sum[17:0]};
  endfunction

  task automatic load_inputs();
    for (int c = 0; c < NCH; c++) begin
      in_samples[c*SMP_W +: SMP_W] = cur_s[c][SMP_W-1:0];
      in_times[c*TIME_W +: TIME_W] = cur_t[c][TIME_W-1:0];
      in_time_ok[c]                = (cur_m[c] != 0);
    end
  endtask

  task automatic fill_vec(input int i);
    for (int c = 0; c < NCH; c++) begin
      cur_s[c] = (VECS[i].base + VECS[i].step * c) & 1023;
      cur_t[c] = (VECS[i].tbase + VECS[i].tstep * c) & 255;
      cur_m[c] = (VECS[i].tmask >> c) & 1;
    end
  endtask

  // apply one set, confirm exact latency, compare the word
  task automatic run_set(input string req);
    logic [LINK_W-1:0] exp;
    exp = model();
    @(negedge clk);
    load_inputs();
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (5) @(negedge clk);
    check({req, " R7 early"}, {47'b0, link_valid}, '0);
    @(negedge clk);
    check({req, " R7 valid"}, {47'b0, link_valid}, 48'd1);
    check(req, link_word, exp);
  endtask

  task automatic cfg_write(input int addr, input int data);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_addr  = addr[CFG_ADDR_W-1:0];
    cfg_wdata = data[CFG_DATA_W-1:0];
    @(negedge clk);
    cfg_we = 1'b0;
    if (addr >= NCH) ped_m[addr - NCH] = data & 1023;
    else             gain_m[addr]      = data & 255;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [LINK_W-1:0] e0, e1;
    for (int c = 0; c < NCH; c++) begin
      gain_m[c] = 64;
      ped_m[c]  = 0;
    end
    rst_n      = 1'b0;
    cfg_we     = 1'b0;
    cfg_addr   = '0;
    cfg_wdata  = '0;
    // R9: stimulus offered during reset
    fill_vec(0);
    load_inputs();
    in_valid = 1'b1;
    repeat (4) @(negedge clk);
    check("R9 reset valid", {47'b0, link_valid}, '0);
    check("R9 reset word", link_word, '0);
    in_valid = 1'b0;
    rst_n    = 1'b1;
    repeat (10) @(negedge clk);
    check("R9 after release", {47'b0, link_valid}, '0);

    // table pass with reset defaults (R3 unity gain, zero pedestal)
    for (int i = 0; i < 6; i++) begin
      fill_vec(i);
      run_set($sformatf("R1 R3 R4 R5 R6 default vec %0d", i));
    end

    // R5: tie between channels 5 and 9
    for (int c = 0; c < NCH; c++) begin
      cur_s[c] = 100; cur_t[c] = 0; cur_m[c] = 0;
    end
    cur_s[5] = 800;
    cur_s[9] = 800;
    run_set("R5 tie");
    check("R5 tie index", {44'b0, link_word[21:18]}, 48'd5);

    // R8: in_valid low offers nothing
    fill_vec(2);
    load_inputs();
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      check("R8 ignored valid", {47'b0, link_valid}, '0);
      check("R8 ignored word", link_word, '0);
    end

    // R7: back-to-back sets
    fill_vec(0);
    e0 = model();
    @(negedge clk);
    load_inputs();
    in_valid = 1'b1;
    fill_vec(4);
    e1 = model();
    @(negedge clk);
    load_inputs();
    @(negedge clk);
    in_valid = 1'b0;
    repeat (5) @(negedge clk);
    check("R7 b2b first", link_word, e0);
    @(negedge clk);
    check("R7 b2b second", link_word, e1);

    // R3: load distinct gains and pedestals
    for (int c = 0; c < NCH; c++) begin
      cfg_write(c, 32 + 13 * c);
      cfg_write(NCH + c, 20 * c);
    end
    // R3: strobe low must not write
    @(negedge clk);
    cfg_addr  = 5'd2;
    cfg_wdata = 10'd1;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      fill_vec(i);
      run_set($sformatf("R1 R2 R3 R4 R5 R6 loaded vec %0d", i));
    end

    // R1 saturation on ch3, R2 clamp on ch0
    cfg_write(3, 255);
    cfg_write(NCH + 3, 0);
    cfg_write(NCH + 0, 1023);
    repeat (2) @(negedge clk);
    for (int c = 0; c < NCH; c++) begin
      cur_s[c] = 1023; cur_t[c] = 30 - c; cur_m[c] = (c == 12) ? 1 : 0;
    end
    run_set("R1 R2 saturate clamp");
    check("R1 saturated peak", {38'b0, link_word[31:22]}, 48'd1023);
    check("R5 peak index ch3", {44'b0, link_word[21:18]}, 48'd3);
    check("R6 single time", {40'b0, link_word[39:32]}, 48'd18);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule